// File: doc/BRIEF.md
# Bulk Command Register-Write Decoder

This block takes a byte stream of bulk commands from a host link and turns register-write commands into updates of a small video control register file. The display path reads the register values straight from its outputs: two 24-bit framebuffer base pointers (one for the 16-bit-per-pixel plane, one for the 8-bit-per-pixel plane), a colour-depth selector, a blanking mode, twelve 16-bit timing fields and a 16-bit pixel-clock field counted in 5 kHz steps.

Every command opens with the prefix byte 0xAF and a command code. A write command carries one address byte and one data byte. A copy command is the only other command recognised. It is swallowed whole, without writing anything, so that the stream stays aligned. A control register at address 0xFF freezes the visible values while the host loads a new mode. Writes made during the freeze collect in shadow copies, and the unlock value publishes all of them on one clock edge. The input is always ready, and a byte moves only in a cycle where `in_valid` is high.

Top module: `bulkcmd_regwr_dec`

## Requirements
- R1: After reset every register output is zero, `cmd_err` is low, the file is unlocked and the parser waits for a prefix.
- R2: The four accepted bytes 0xAF, 0x20, address, data write the data byte to the addressed register. While the file is unlocked, the new value shows at the output from the clock edge that accepts the data byte.
- R3: In the prefix position, any byte other than 0xAF is dropped without effect, and decoding restarts at the next 0xAF.
- R4: The code 0x6A starts a copy command of nine bytes in total. The seven bytes after the code are consumed and write nothing, even when they look like a write command.
- R5: A code byte that is neither 0x20 nor 0x6A sets `cmd_err`. The flag stays high until reset, and the parser goes back to waiting for a prefix.
- R6: `base16_addr` is formed from registers 0x20 (bits 23:16), 0x21 (bits 15:8) and 0x22 (bits 7:0). `base8_addr` is formed the same way from 0x26, 0x27 and 0x28.
- R7: Timing field k (k = 0..11) takes its high byte from register 0x01+2k and its low byte from register 0x02+2k.
- R8: `pix_clk_5k` takes its low byte from register 0x1B and its high byte from register 0x1C.
- R9: Writing 0x00 to register 0xFF locks the file. While it is locked, writes go only to the shadow copies and no register output changes.
- R10: Writing 0xFF to register 0xFF unlocks the file. Every value written during the lock shows at the outputs together, on the edge that accepts that data byte.
- R11: `color_depth` is register 0x00 and `blank_mode` is register 0x1F.
- R12: A cycle with `in_valid` low changes neither the parse position nor any output. `in_ready` is always high.
- R13: A write to an address that has no register changes no output. A write to 0xFF with a value other than 0x00 or 0xFF leaves the lock state as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | A byte is present on `in_data` |
| in_data | input | 8 | Command stream byte |
| in_ready | output | 1 | Always high: one byte is taken in each valid cycle |
| base16_addr | output | 24 | Base pointer of the 16-bit-per-pixel plane |
| base8_addr | output | 24 | Base pointer of the 8-bit-per-pixel plane |
| color_depth | output | 8 | Colour-depth selector |
| blank_mode | output | 8 | Blanking mode |
| timing | output | 12x16 | Timing fields, index k from registers 0x01+2k and 0x02+2k |
| pix_clk_5k | output | 16 | Pixel clock in 5 kHz units |
| cmd_err | output | 1 | Sticky flag for an unknown command code |

## Verification
A register result becomes due on the rising edge that accepts the data byte of its write. The unlock transfer is due on the edge that accepts the 0xFF data byte, and the error flag on the edge that accepts the unknown code. The bench applies each byte just after a falling edge and updates a behavioural model for that byte at the same moment. At the next falling edge it compares every output with the model. That comparison lands one edge after the byte is accepted, which is exactly where each result is due. Directed checks with fixed constants follow the falling edge that comes after each sequence's last byte. Around a lock, they are placed both before and after the unlock byte, which shows that the values are held and then released in a single edge.

// File: rtl/bcd_pkg.sv
package bcd_pkg;

  typedef enum logic [2:0] {
    PS_PREFIX,
    PS_CODE,
    PS_ADDR,
    PS_DATA,
    PS_SKIP
  } bcd_state_e;

  localparam logic [7:0] BCD_PREFIX     = 8'hAF;
  localparam logic [7:0] BCD_WR_CODE    = 8'h20;
  localparam logic [7:0] BCD_COPY_CODE  = 8'h6A;
  localparam int         BCD_COPY_LEN   = 9;

  localparam logic [7:0] BCD_CTRL_ADDR  = 8'hFF;
  localparam logic [7:0] BCD_LOCK_VAL   = 8'h00;
  localparam logic [7:0] BCD_UNLOCK_VAL = 8'hFF;

  localparam logic [7:0] BCD_DEPTH_ADDR = 8'h00;
  localparam logic [7:0] BCD_BLANK_ADDR = 8'h1F;
  localparam logic [7:0] BCD_B16_ADDR   = 8'h20;
  localparam logic [7:0] BCD_B8_ADDR    = 8'h26;
  localparam logic [7:0] BCD_TIM_ADDR   = 8'h01;
  localparam logic [7:0] BCD_PCLK_ADDR  = 8'h1B;

endpackage

// File: rtl/bcd_rst_sync.sv
module bcd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);

  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_s_n = sh_q[STAGES-1];

endmodule

// File: rtl/bcd_parser.sv
module bcd_parser
  import bcd_pkg::*;
#(
  parameter logic [7:0] PREFIX    = BCD_PREFIX,
  parameter logic [7:0] WR_CODE   = BCD_WR_CODE,
  parameter logic [7:0] COPY_CODE = BCD_COPY_CODE,
  parameter int         COPY_LEN  = BCD_COPY_LEN
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       wr_en,
  output logic [7:0] wr_addr,
  output logic [7:0] wr_data,
  output logic       err
);

  localparam int CNT_W   = $clog2(COPY_LEN);
  localparam int PAYLOAD = COPY_LEN - 2;

  bcd_state_e       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [7:0]       addr_q, addr_d;
  logic             err_q, err_d;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    addr_d = addr_q;
    err_d  = err_q;
    wr_en  = 1'b0;
    if (in_valid) begin
      unique case (st_q)
        PS_PREFIX: begin
          if (in_data == PREFIX) st_d = PS_CODE;
        end
        PS_CODE: begin
          if (in_data == WR_CODE) begin
            st_d = PS_ADDR;
          end else if (in_data == COPY_CODE) begin
            st_d  = PS_SKIP;
            cnt_d = CNT_W'(PAYLOAD - 1);
          end else begin
            err_d = 1'b1;
            st_d  = PS_PREFIX;
          end
        end
        PS_ADDR: begin
          addr_d = in_data;
          st_d   = PS_DATA;
        end
        PS_DATA: begin
          wr_en = 1'b1;
          st_d  = PS_PREFIX;
        end
        PS_SKIP: begin
          if (cnt_q == '0) st_d = PS_PREFIX;
          else             cnt_d = cnt_q - 1'b1;
        end
        default: st_d = PS_PREFIX;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= PS_PREFIX;
      cnt_q  <= '0;
      addr_q <= '0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      addr_q <= addr_d;
      err_q  <= err_d;
    end
  end

  assign wr_addr = addr_q;
  assign wr_data = in_data;
  assign err     = err_q;

endmodule

// File: rtl/bcd_vidregs.sv
module bcd_vidregs
  import bcd_pkg::*;
#(
  parameter int         N_TIM      = 12,
  parameter logic [7:0] CTRL_ADDR  = BCD_CTRL_ADDR,
  parameter logic [7:0] LOCK_VAL   = BCD_LOCK_VAL,
  parameter logic [7:0] UNLOCK_VAL = BCD_UNLOCK_VAL,
  parameter logic [7:0] DEPTH_ADDR = BCD_DEPTH_ADDR,
  parameter logic [7:0] BLANK_ADDR = BCD_BLANK_ADDR,
  parameter logic [7:0] B16_ADDR   = BCD_B16_ADDR,
  parameter logic [7:0] B8_ADDR    = BCD_B8_ADDR,
  parameter logic [7:0] TIM_ADDR   = BCD_TIM_ADDR,
  parameter logic [7:0] PCLK_ADDR  = BCD_PCLK_ADDR
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [7:0]            wr_addr,
  input  logic [7:0]            wr_data,
  output logic                  locked,
  output logic [23:0]           base16_addr,
  output logic [23:0]           base8_addr,
  output logic [7:0]            color_depth,
  output logic [7:0]            blank_mode,
  output logic [N_TIM-1:0][15:0] timing,
  output logic [15:0]           pix_clk_5k
);

  // slot layout: 0 depth, 1 blank, 2..4 base16 (msb first), 5..7 base8,
  // then timing byte pairs, then pixel clock low/high
  localparam int S_B16  = 2;
  localparam int S_B8   = 5;
  localparam int S_TIM  = 8;
  localparam int S_PCLK = S_TIM + 2 * N_TIM;
  localparam int NSLOT  = S_PCLK + 2;

  function automatic logic [7:0] slot_addr(input int i);
    if (i == 0)           return DEPTH_ADDR;
    else if (i == 1)      return BLANK_ADDR;
    else if (i < S_B8)    return 8'(int'(B16_ADDR) + i - S_B16);
    else if (i < S_TIM)   return 8'(int'(B8_ADDR) + i - S_B8);
    else if (i < S_PCLK)  return 8'(int'(TIM_ADDR) + i - S_TIM);
    else                  return 8'(int'(PCLK_ADDR) + i - S_PCLK);
  endfunction

  logic [NSLOT-1:0]      hit;
  logic [NSLOT-1:0][7:0] act_q, act_d;
  logic [NSLOT-1:0][7:0] shd_q, shd_d;
  logic                  lock_q, lock_d;
  logic                  ctrl_wr, do_lock, do_unlock;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    localparam logic [7:0] SA = slot_addr(g);
    assign hit[g] = wr_en && (wr_addr == SA);
  end

  assign ctrl_wr   = wr_en && (wr_addr == CTRL_ADDR);
  assign do_lock   = ctrl_wr && (wr_data == LOCK_VAL);
  assign do_unlock = ctrl_wr && (wr_data == UNLOCK_VAL);

  always_comb begin
    shd_d  = shd_q;
    act_d  = act_q;
    lock_d = lock_q;
    for (int i = 0; i < NSLOT; i++) begin
      if (hit[i]) begin
        shd_d[i] = wr_data;
        if (!lock_q) act_d[i] = wr_data;
      end
    end
    if (do_unlock) begin
      act_d  = shd_q;
      lock_d = 1'b0;
    end else if (do_lock) begin
      lock_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= '0;
      shd_q  <= '0;
      lock_q <= 1'b0;
    end else begin
      act_q  <= act_d;
      shd_q  <= shd_d;
      lock_q <= lock_d;
    end
  end

  assign locked      = lock_q;
  assign color_depth = act_q[0];
  assign blank_mode  = act_q[1];
  assign base16_addr = {act_q[S_B16], act_q[S_B16+1], act_q[S_B16+2]};
  assign base8_addr  = {act_q[S_B8],  act_q[S_B8+1],  act_q[S_B8+2]};
  assign pix_clk_5k  = {act_q[S_PCLK+1], act_q[S_PCLK]};

  for (genvar k = 0; k < N_TIM; k++) begin : g_tim
    assign timing[k] = {act_q[S_TIM+2*k], act_q[S_TIM+2*k+1]};
  end

endmodule

// File: rtl/bulkcmd_regwr_dec.sv
module bulkcmd_regwr_dec
  import bcd_pkg::*;
#(
  parameter int N_TIM = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [7:0]            in_data,
  output logic                  in_ready,
  output logic [23:0]           base16_addr,
  output logic [23:0]           base8_addr,
  output logic [7:0]            color_depth,
  output logic [7:0]            blank_mode,
  output logic [N_TIM-1:0][15:0] timing,
  output logic [15:0]           pix_clk_5k,
  output logic                  cmd_err
);

  logic       rst_s_n;
  logic       wr_en;
  logic [7:0] wr_addr;
  logic [7:0] wr_data;
  logic       lock_q;

  assign in_ready = 1'b1;

  bcd_rst_sync #(.STAGES(2)) rst_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  bcd_parser parse_i (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .in_valid (in_valid),
    .in_data  (in_data),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .err      (cmd_err)
  );

  bcd_vidregs #(.N_TIM(N_TIM)) regs_i (
    .clk         (clk),
    .rst_n       (rst_s_n),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .locked      (lock_q),
    .base16_addr (base16_addr),
    .base8_addr  (base8_addr),
    .color_depth (color_depth),
    .blank_mode  (blank_mode),
    .timing      (timing),
    .pix_clk_5k  (pix_clk_5k)
  );

endmodule

// File: rtl/bcd_checker.sv
module bcd_checker #(
  parameter int OUT_W = 272
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             wr_en,
  input logic [7:0]       wr_addr,
  input logic [7:0]       wr_data,
  input logic             lock_q,
  input logic             err,
  input logic [7:0]       color_depth,
  input logic [OUT_W-1:0] outs
);

  // R2: a decoded write never appears without a byte on the input
  p_wr_needs_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> in_valid);

  // R2 / R11: an unlocked write to the depth register lands on the next edge
  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !lock_q && wr_addr == 8'h00) |=> (color_depth == $past(wr_data)));

  // R5: the error flag is sticky
  p_err_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  // R9: outputs frozen while locked unless the unlock arrives
  p_hold_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && !(wr_en && wr_addr == 8'hFF && wr_data == 8'hFF)) |=> $stable(outs));

  // R12: idle cycles change nothing visible
  p_stall_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(outs) && $stable(err)));

endmodule

bind bulkcmd_regwr_dec bcd_checker #(.OUT_W(80 + 16 * N_TIM)) chk_i (
  .clk         (clk),
  .rst_n       (rst_s_n),
  .in_valid    (in_valid),
  .wr_en       (wr_en),
  .wr_addr     (wr_addr),
  .wr_data     (wr_data),
  .lock_q      (lock_q),
  .err         (cmd_err),
  .color_depth (color_depth),
  .outs        ({base16_addr, base8_addr, color_depth, blank_mode, timing, pix_clk_5k})
);

// File: tb/bulkcmd_regwr_dec_tb_top.sv
`timescale 1ns/1ps
module bulkcmd_regwr_dec_tb_top;

  localparam int N_TIM = 12;

  logic                  clk = 1'b0;
  logic                  rst_n;
  logic                  in_valid;
  logic [7:0]            in_data;
  logic                  in_ready;
  logic [23:0]           base16_addr;
  logic [23:0]           base8_addr;
  logic [7:0]            color_depth;
  logic [7:0]            blank_mode;
  logic [N_TIM-1:0][15:0] timing;
  logic [15:0]           pix_clk_5k;
  logic                  cmd_err;

  always #4 clk = ~clk;

  bulkcmd_regwr_dec #(.N_TIM(N_TIM)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_data     (in_data),
    .in_ready    (in_ready),
    .base16_addr (base16_addr),
    .base8_addr  (base8_addr),
    .color_depth (color_depth),
    .blank_mode  (blank_mode),
    .timing      (timing),
    .pix_clk_5k  (pix_clk_5k),
    .cmd_err     (cmd_err)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  string cur_req = "R1";

  // behavioural reference: byte-addressed register space plus parse position
  int m_act[256];
  int m_shd[256];
  bit m_lock;
  int m_st;
  int m_cnt;
  int m_adr;
  bit m_err;

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp_v);
    n_cmp++;
    if (got !== exp_v) begin
      n_bad++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp_v);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 256; i++) begin
      m_act[i] = 0;
      m_shd[i] = 0;
    end
    m_lock = 0; m_st = 0; m_cnt = 0; m_adr = 0; m_err = 0;
  endtask

  task automatic model_step(input bit v, input int b);
    if (!v) return;
    case (m_st)
      0: if (b == 'hAF) m_st = 1;
      1: begin
        if (b == 'h20) m_st = 2;
        else if (b == 'h6A) begin m_st = 4; m_cnt = 7; end
        else begin m_err = 1; m_st = 0; end
      end
      2: begin m_adr = b; m_st = 3; end
      3: begin
        if (m_adr == 'hFF) begin
          if (b == 'h00) m_lock = 1;
          else if (b == 'hFF) begin
            m_lock = 0;
            for (int i = 0; i < 256; i++) m_act[i] = m_shd[i];
          end
        end else begin
          m_shd[m_adr] = b;
          if (!m_lock) m_act[m_adr] = b;
        end
        m_st = 0;
      end
      default: begin
        m_cnt--;
        if (m_cnt == 0) m_st = 0;
      end
    endcase
  endtask

  function automatic logic [7:0] mb(input int a);
    return 8'(m_act[a]);
  endfunction

  task automatic compare_all();
    chk(cur_req, "base16_addr", 32'(base16_addr), 32'({mb('h20), mb('h21), mb('h22)}));
    chk(cur_req, "base8_addr", 32'(base8_addr), 32'({mb('h26), mb('h27), mb('h28)}));
    chk(cur_req, "color_depth", 32'(color_depth), 32'(mb('h00)));
    chk(cur_req, "blank_mode", 32'(blank_mode), 32'(mb('h1F)));
    for (int k = 0; k < N_TIM; k++)
      chk(cur_req, $sformatf("timing[%0d]", k), 32'(timing[k]),
          32'({mb(1 + 2 * k), mb(2 + 2 * k)}));
    chk(cur_req, "pix_clk_5k", 32'(pix_clk_5k), 32'({mb('h1C), mb('h1B)}));
    chk(cur_req, "cmd_err", 32'(cmd_err), 32'(m_err));
    chk("R12", "in_ready", 32'(in_ready), 32'd1);
  endtask

  task automatic tick(input bit v, input int b);
    @(negedge clk);
    compare_all();
    in_valid = v;
    in_data  = 8'(b);
    model_step(v, b);
  endtask

  task automatic wr(input int a, input int d);
    tick(1, 'hAF);
    tick(1, 'h20);
    tick(1, a);
    tick(1, d);
    tick(0, 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : stim
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_data = 8'h00;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) tick(0, 0);

    // R1: reset state
    cur_req = "R1";
    chk("R1", "base16_addr", 32'(base16_addr), 32'h0);
    chk("R1", "pix_clk_5k", 32'(pix_clk_5k), 32'h0);
    chk("R1", "cmd_err", 32'(cmd_err), 32'h0);

    // R2, R11: plain writes
    cur_req = "R11";
    wr('h00, 'h03);
    chk("R11", "color_depth", 32'(color_depth), 32'h03);
    wr('h1F, 'h01);
    chk("R11", "blank_mode", 32'(blank_mode), 32'h01);

    // R2: result due on the edge accepting the data byte
    cur_req = "R2";
    tick(1, 'hAF); tick(1, 'h20); tick(1, 'h1F); tick(1, 'h05);
    tick(0, 0);
    chk("R2", "blank_mode next edge", 32'(blank_mode), 32'h05);

    // R6: base pointers, msb at lowest address
    cur_req = "R6";
    wr('h20, 'h12); wr('h21, 'h34); wr('h22, 'h56);
    chk("R6", "base16_addr", 32'(base16_addr), 32'h123456);
    wr('h26, 'hAB); wr('h27, 'hCD); wr('h28, 'hEF);
    chk("R6", "base8_addr", 32'(base8_addr), 32'hABCDEF);

    // R7: timing fields, high byte first
    cur_req = "R7";
    wr('h01, 'h12); wr('h02, 'h34);
    chk("R7", "timing[0]", 32'(timing[0]), 32'h1234);
    wr('h17, 'hBE); wr('h18, 'hEF);
    chk("R7", "timing[11]", 32'(timing[11]), 32'hBEEF);

    // R8: pixel clock, low byte first
    cur_req = "R8";
    wr('h1B, 'h34); wr('h1C, 'h12);
    chk("R8", "pix_clk_5k", 32'(pix_clk_5k), 32'h1234);

    // R3: junk before a prefix is dropped
    cur_req = "R3";
    tick(1, 'h00); tick(1, 'h55); tick(1, 'h20); tick(1, 'h00);
    wr('h00, 'h04);
    chk("R3", "color_depth after resync", 32'(color_depth), 32'h04);

    // R4: copy command swallowed, including a write-shaped payload
    cur_req = "R4";
    tick(1, 'hAF); tick(1, 'h6A);
    tick(1, 'hAF); tick(1, 'h20); tick(1, 'h00); tick(1, 'h77);
    tick(1, 'hAF); tick(1, 'h20); tick(1, 'h00);
    tick(0, 0);
    chk("R4", "color_depth untouched", 32'(color_depth), 32'h04);
    wr('h00, 'h06);
    chk("R4", "aligned after copy", 32'(color_depth), 32'h06);

    // R12: stalls between bytes
    cur_req = "R12";
    tick(1, 'hAF); tick(0, 'h00); tick(1, 'h20); tick(0, 'hAF);
    tick(1, 'h1F); tick(0, 'h20); tick(1, 'h09); tick(0, 0);
    chk("R12", "blank_mode with stalls", 32'(blank_mode), 32'h09);

    // R13: unmapped address and odd control value
    cur_req = "R13";
    wr('h40, 'h99);
    chk("R13", "color_depth after unmapped", 32'(color_depth), 32'h06);
    wr('hFF, 'h55);
    wr('h00, 'h07);
    chk("R13", "no lock from 0x55", 32'(color_depth), 32'h07);

    // R9 / R10: lock, shadow, release
    cur_req = "R9";
    wr('hFF, 'h00);
    wr('h00, 'h09);
    wr('h20, 'h01); wr('h21, 'h02); wr('h22, 'h03);
    wr('h1B, 'hCD); wr('h1C, 'hAB);
    chk("R9", "color_depth held", 32'(color_depth), 32'h07);
    chk("R9", "base16 held", 32'(base16_addr), 32'h123456);
    chk("R9", "pix_clk held", 32'(pix_clk_5k), 32'h1234);
    cur_req = "R10";
    wr('hFF, 'hFF);
    chk("R10", "color_depth released", 32'(color_depth), 32'h09);
    chk("R10", "base16 released", 32'(base16_addr), 32'h010203);
    chk("R10", "pix_clk released", 32'(pix_clk_5k), 32'hABCD);
    wr('h00, 'h0A);
    chk("R10", "unlocked direct write", 32'(color_depth), 32'h0A);

    // R5: unknown code, sticky flag
    cur_req = "R5";
    tick(1, 'hAF); tick(1, 'h33); tick(0, 0);
    chk("R5", "cmd_err set", 32'(cmd_err), 32'h1);
    wr('h00, 'h0B);
    chk("R5", "write after error", 32'(color_depth), 32'h0B);
    chk("R5", "cmd_err sticky", 32'(cmd_err), 32'h1);

    repeat (3) tick(0, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule